// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls a port of up to 32 general-purpose pins and is reached through a simple 32-bit register bus with word-aligned offsets. For each pin it holds four things: a direction bit, an output-enable bit, an output value and a hand-off bit. The hand-off bit gives the pin's pad either to register control or to an alternate-function path elsewhere in the chip. The pad input of every pin is resynchronised by a two-flop chain. The result is readable over the bus and is also passed out for a separate interrupt detector.

Under register control, a pin drives its pad only when two conditions hold: its direction bit marks it as an output, and its output-enable bit is set. When a pin is handed off, its pad output value and pad enable come straight from the alternate-function inputs. A parameter sets the pin count. Bits at or above that count do not exist: they read as zero and ignore writes.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register is all ones (every pin an input), the output-enable and output-value registers are zero, and the hand-off register holds the BYPASS_RST parameter value.
- R2: Offsets: 0x00 is the hand-off register, 0x04 direction, 0x08 output enable, 0x0C output value, and 0x10 the read-only input value, where a write has no effect. Read data appears on bus_rdata in the cycle after the read request and is zero in any cycle that follows no read.
- R3: For a pin under register control (hand-off bit 0), pad_oe is 1 exactly when its direction bit is 0 (output) and its output-enable bit is 1.
- R4: For a pin whose direction bit is 1 (input) and which is under register control, the output-enable bit has no effect and pad_oe stays 0.
- R5: For a pin under register control, pad_out equals its output-value register bit, whatever the enable state.
- R6: For a pin whose hand-off bit is 1, pad_out equals alt_out and pad_oe equals alt_oe for that pin, combinationally and regardless of the other registers.
- R7: Reading offset 0x0C returns the last value written there, not the pad state.
- R8: A change on pad_in appears on pin_sync after exactly two rising clock edges. A read of offset 0x10 returns pin_sync.
- R9: Register bits at or above NPINS read as zero, and writes to them are discarded.
- R10: Reads of any unmapped or misaligned offset return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad driver enables |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function driver enables |
| pin_sync | output | NPINS | Synchronised pad inputs for interrupt logic |

## Verification
A bus write to the hand-off register can land in the same cycle in which the alternate-function inputs change. The bench provokes this by presenting new alt_out and alt_oe values in the same half-cycle as a write that returns the pins to register control. It then samples the pads before and after the capturing edge. Before the edge, the handed-off pins must already show the new alternate values. After the edge, the same pins must show their register-controlled value and enable.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int OFS_BYP = 'h00;
   localparam int OFS_DIR = 'h04;
   localparam int OFS_OE  = 'h08;
   localparam int OFS_OUT = 'h0C;
   localparam int OFS_IN  = 'h10;

   localparam int BUS_W   = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_BYP,
      SEL_DIR,
      SEL_OE,
      SEL_OUT,
      SEL_IN
   } gp_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_raw,
   output logic [W-1:0] d_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= d_raw;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int          NPINS      = 32,
   parameter int          ADDR_W     = 8,
   parameter logic [31:0] BYPASS_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  byp_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  oe_q,
   output logic [NPINS-1:0]  out_q
);

   localparam logic [NPINS-1:0] BYP_INIT = BYPASS_RST[NPINS-1:0];
   localparam logic [NPINS-1:0] DIR_INIT = '1;

   function automatic gp_sel_e f_decode(input logic [ADDR_W-1:0] a);
      gp_sel_e r;
      r = SEL_NONE;
      if (a == ADDR_W'(OFS_BYP)) r = SEL_BYP;
      if (a == ADDR_W'(OFS_DIR)) r = SEL_DIR;
      if (a == ADDR_W'(OFS_OE))  r = SEL_OE;
      if (a == ADDR_W'(OFS_OUT)) r = SEL_OUT;
      if (a == ADDR_W'(OFS_IN))  r = SEL_IN;
      return r;
   endfunction

   gp_sel_e          sel;
   logic             wr_req;
   logic             rd_req;
   logic [NPINS-1:0] wr_bits;
   logic [NPINS-1:0] rd_bits;
   logic [BUS_W-1:0] rd_ext;

   assign sel     = f_decode(bus_addr);
   assign wr_req  = bus_sel &  bus_wr;
   assign rd_req  = bus_sel & ~bus_wr;
   assign wr_bits = bus_wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= BYP_INIT;
         dir_q <= DIR_INIT;
         oe_q  <= '0;
         out_q <= '0;
      end else if (wr_req) begin
         case (sel)
            SEL_BYP: byp_q <= wr_bits;
            SEL_DIR: dir_q <= wr_bits;
            SEL_OE:  oe_q  <= wr_bits;
            SEL_OUT: out_q <= wr_bits;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_BYP: rd_bits = byp_q;
         SEL_DIR: rd_bits = dir_q;
         SEL_OE:  rd_bits = oe_q;
         SEL_OUT: rd_bits = out_q;
         SEL_IN:  rd_bits = pin_in;
         default: rd_bits = '0;
      endcase
   end

   if (NPINS < BUS_W) begin : g_pad_rd
      assign rd_ext = {{(BUS_W-NPINS){1'b0}}, rd_bits};
   end else begin : g_full_rd
      assign rd_ext = rd_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         bus_rdata <= rd_ext;
      end else begin
         bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux #(
   parameter int NPINS = 32
) (
   input  logic [NPINS-1:0] byp_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] oe_q,
   input  logic [NPINS-1:0] out_q,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic reg_drive;
      assign reg_drive  = ~dir_q[p] & oe_q[p];
      assign pad_out[p] = byp_q[p] ? alt_out[p] : out_q[p];
      assign pad_oe[p]  = byp_q[p] ? alt_oe[p]  : reg_drive;
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int          NPINS      = 32,
   parameter int          ADDR_W     = 8,
   parameter logic [31:0] BYPASS_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  pin_sync
);

   localparam int SYNC_STAGES = 2;

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_port: NPINS must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_port: ADDR_W must reach offset 0x10");
   end

   logic [NPINS-1:0] byp_q;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] oe_q;
   logic [NPINS-1:0] out_q;

   gpio_port_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_raw  (pad_in),
      .d_sync (pin_sync)
   );

   gpio_port_regs #(
      .NPINS      (NPINS),
      .ADDR_W     (ADDR_W),
      .BYPASS_RST (BYPASS_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_sync),
      .byp_q     (byp_q),
      .dir_q     (dir_q),
      .oe_q      (oe_q),
      .out_q     (out_q)
   );

   gpio_port_padmux #(
      .NPINS (NPINS)
   ) u_padmux (
      .byp_q   (byp_q),
      .dir_q   (dir_q),
      .oe_q    (oe_q),
      .out_q   (out_q),
      .alt_out (alt_out),
      .alt_oe  (alt_oe),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pin_sync,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  alt_out,
   input logic [NPINS-1:0]  byp_q,
   input logic [NPINS-1:0]  dir_q,
   input logic [NPINS-1:0]  out_q
);

   logic [31:0] pin_mask32;
   logic [1:0]  up_cnt;

   always_comb begin
      pin_mask32 = '0;
      pin_mask32[NPINS-1:0] = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            up_cnt <= '0;
      else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
   end

   // R2: no read request -> zero read data next cycle
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> (bus_rdata == 32'd0));

   // R4: input pins under register control never drive
   a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_q & ~byp_q & pad_oe) == '0));

   // R6: handed-off pins follow the alternate output
   a_r6_alt_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ((byp_q & (pad_out ^ alt_out)) == '0));

   // R7: output value only changes on a write to its offset
   a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_OUT)) |=> $stable(out_q));

   // R8: two-edge synchronizer delay
   a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

   // R9: nonexistent bits always read zero
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata & ~pin_mask32) == 32'd0));

endmodule

bind gpio_port gpio_port_chk #(
   .NPINS  (NPINS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pin_sync  (pin_sync),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .alt_out   (alt_out),
   .byp_q     (byp_q),
   .dir_q     (dir_q),
   .out_q     (out_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

   localparam int          NP     = 20;
   localparam int          AW     = 8;
   localparam logic [31:0] BRST   = 32'h0000_000F;
   localparam logic [31:0] MASK   = 32'h000F_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic [NP-1:0] alt_out = '0;
   logic [NP-1:0] alt_oe = '0;
   logic [NP-1:0] pin_sync;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model of register contents, from the requirements
   logic [31:0] m_byp, m_dir, m_oe, m_out;

   always #5 clk = ~clk;

   gpio_port #(.NPINS(NP), .ADDR_W(AW), .BYPASS_RST(BRST)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .pin_sync(pin_sync)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] exp_oe();
      return ((~m_dir & m_oe & ~m_byp) | ({12'd0, alt_oe} & m_byp)) & MASK;
   endfunction

   function automatic logic [31:0] exp_out();
      return ((m_out & ~m_byp) | ({12'd0, alt_out} & m_byp)) & MASK;
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 bypass reset", d, BRST);
      rd(8'h04, d); chk("R1 direction reset", d, MASK);
      rd(8'h08, d); chk("R1 enable reset", d, 32'd0);
      rd(8'h0C, d); chk("R1 outval reset", d, 32'd0);
      chk("R1 pad_oe reset", {12'd0, pad_oe}, 32'd0);
      @(negedge clk);
      chk("R2 rdata idle zero", bus_rdata, 32'd0);
   endtask

   task automatic t_drive();
      m_byp = 32'd0; m_dir = 32'h000F_FF00; m_oe = 32'h0000_F0FF; m_out = 32'h000A_5A5A;
      wr(8'h00, m_byp); wr(8'h04, m_dir); wr(8'h08, m_oe); wr(8'h0C, m_out);
      chk("R3 R4 pad_oe", {12'd0, pad_oe}, 32'h0000_00FF);
      chk("R5 pad_out", {12'd0, pad_out}, m_out);
      m_oe = 32'h0000_0000;
      wr(8'h08, m_oe);
      chk("R5 pad_out with drivers off", {12'd0, pad_out}, m_out);
      chk("R3 pad_oe off", {12'd0, pad_oe}, 32'd0);
      m_oe = 32'h0000_F0FF;
      wr(8'h08, m_oe);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      pad_in = ~m_out[NP-1:0];
      repeat (3) @(negedge clk);
      rd(8'h0C, d); chk("R7 outval readback", d, m_out);
      rd(8'h10, d); chk("R8 input differs from outval", d, {12'd0, ~m_out[NP-1:0]});
   endtask

   task automatic t_bypass();
      alt_out = 20'hFFFFF; alt_oe = 20'hFFFFE;
      m_byp = 32'h0000_0003;
      wr(8'h00, m_byp);
      chk("R6 bypass pad_out", {12'd0, pad_out}, exp_out());
      chk("R6 bypass pad_oe", {12'd0, pad_oe}, exp_oe());
      // same-cycle: alt inputs change while a write releases the hand-off
      @(negedge clk);
      alt_out = 20'h00000; alt_oe = 20'h00003;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'd0;
      #1;
      chk("R6 alt change before edge out", {12'd0, pad_out}, exp_out());
      chk("R6 alt change before edge oe", {12'd0, pad_oe}, exp_oe());
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      m_byp = 32'd0;
      chk("R3 released pins oe", {12'd0, pad_oe}, exp_oe());
      chk("R5 released pins out", {12'd0, pad_out}, exp_out());
   endtask

   task automatic t_sync();
      logic [31:0] d;
      logic [NP-1:0] prev;
      prev = pin_sync;
      @(negedge clk);
      pad_in = 20'h12345;
      @(negedge clk);
      chk("R8 one edge still old", {12'd0, pin_sync}, {12'd0, prev});
      @(negedge clk);
      chk("R8 two edges new", {12'd0, pin_sync}, 32'h0001_2345);
      rd(8'h10, d); chk("R8 input read", d, 32'h0001_2345);
      wr(8'h10, 32'd0);
      rd(8'h10, d); chk("R2 input reg read-only", d, 32'h0001_2345);
   endtask

   task automatic t_upper();
      logic [31:0] d;
      m_oe = 32'hFFFF_FFFF & MASK;
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, d); chk("R9 upper bits zero", d, m_oe);
      chk("R3 all enables", {12'd0, pad_oe}, exp_oe());
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h14, 32'hDEAD_BEEF);
      wr(8'h05, 32'h0000_0000);
      rd(8'h14, d); chk("R10 unmapped read", d, 32'd0);
      rd(8'h01, d); chk("R10 misaligned read", d, 32'd0);
      rd(8'h04, d); chk("R10 direction unchanged", d, m_dir);
      rd(8'h0C, d); chk("R10 outval unchanged", d, m_out);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_drive();
      t_readback();
      t_bypass();
      t_sync();
      t_upper();
      t_unmapped();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule